// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus master byte-wide access to a small register file. It runs entirely on the system clock. The raw SCL and SDA pins are oversampled through synchronisers. The block drives SDA only through an open-drain enable, so a high `sda_oe` pulls the line low. The block answers to one fixed 7-bit bus address. The first byte written after that address loads an internal register pointer.

In a write transfer, the byte that follows the pointer is the new value for the addressed register. Only addresses marked writable are really updated. In a read transfer, which normally follows a pointer write and a repeated start, the block returns consecutive registers starting at the pointer. It keeps doing so for as long as the master acknowledges each byte. Once the last register of the map has gone out, it stops supplying data. Multi-byte quantities in the register file are held with their least significant byte at the lowest address, so a burst delivers them low byte first.

The register file sits outside this block and is reached through a one-cycle read strobe and a write strobe that share one address bus. The pointer survives a STOP condition. A later read that carries no pointer byte therefore resumes where the previous transfer left off.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset, `sda_oe`, `reg_rd_en` and `reg_wr_en` are 0 and the pointer is 0, so the first read after reset returns register 0.
- R2: The block acknowledges an address byte whose upper seven bits equal `DEV_ADDR` (default 0x32). Any other address gets no acknowledge, and every byte up to the next START is ignored without acknowledge.
- R3: Bit 0 of the address byte selects the direction (0 = write, 1 = read). In a write, the first byte after the address is acknowledged and becomes the register pointer.
- R4: A value byte that follows the pointer is acknowledged. If the pointer equals `WR_ADDR_A` (0x04) or `WR_ADDR_B` (0x56), one `reg_wr_en` pulse carries that pointer on `reg_addr` and the byte on `reg_wdata`.
- R5: A value byte aimed at any other address is acknowledged but discarded, with no `reg_wr_en` pulse.
- R6: Only one value byte is accepted per write. Any further byte in the same transfer is not acknowledged and causes no write.
- R7: A read returns registers at consecutive addresses, starting at the pointer, for as long as the master acknowledges. Data is sent most significant bit first.
- R8: `reg_rd_en` is never issued for an address at or beyond `MAP_BYTES` (default 0x70). Once the last register has been sent, SDA stays released, so every further data byte reads 0xFF.
- R9: A master NACK ends the read. The block releases SDA and ignores the bus until the next START.
- R10: The pointer advances by one for each value byte written and each data byte sent. It saturates at `MAP_BYTES` and keeps its value across a STOP.
- R11: An SDA fall while SCL is high (START, or repeated START) restarts the address phase. An SDA rise while SCL is high (STOP) returns the block to idle.
- R12: `sda_oe` changes only while the synchronised SCL is low.
- R13: `reg_rdata` is captured in the cycle after the `reg_rd_en` pulse, and `reg_rd_en` and `reg_wr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register address for both strobes |
| reg_rd_en | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd_en` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |

## Verification
The bench builds the block with its default parameters: address 0x32, a 0x70-byte map, writable registers 0x04 and 0x56, and two synchroniser stages. With a 112-byte map, a pointer write to 0x6E brings the end-of-map boundary within two data bytes, so the release of SDA and the saturation of the pointer both appear in a short burst. Each SCL half period lasts twenty system clocks, which leaves the synchroniser delay and the one-cycle read latency well inside a single bit.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  // True when a value byte at this address may reach the register file.
  function automatic logic reg_writable(input logic [BYTE_W-1:0] a,
                                        input logic [BYTE_W-1:0] wa,
                                        input logic [BYTE_W-1:0] wb);
    return (a == wa) || (a == wb);
  endfunction

  // Address still inside the register map.
  function automatic logic in_map(input logic [BYTE_W-1:0] a,
                                  input logic [BYTE_W-1:0] map_end);
    return a < map_end;
  endfunction

  // Pointer step: plus one, held once it reaches the end of the map.
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] map_end);
    return (a < map_end) ? a + 1'b1 : map_end;
  endfunction

  // Pointer load from the bus: addresses past the map clamp to its end.
  function automatic logic [BYTE_W-1:0] ptr_load(input logic [BYTE_W-1:0] b,
                                                 input logic [BYTE_W-1:0] map_end);
    return (b < map_end) ? b : map_end;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition.
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_regmap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h32,
  parameter int         MAP_BYTES = 112,
  parameter logic [7:0] WR_ADDR_A = 8'h04,
  parameter logic [7:0] WR_ADDR_B = 8'h56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_evt,
  input  logic        stop_evt,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic        reg_rd_en,
  input  logic [7:0]  reg_rdata,
  output logic        reg_wr_en,
  output logic [7:0]  reg_wdata,
  output logic        busy
);
  localparam logic [7:0] MAP_END = 8'(MAP_BYTES);

  tgt_state_e  state;
  logic [3:0]  cnt;
  logic [7:0]  sr;
  logic [7:0]  tx;
  logic [7:0]  ptr;
  logic        is_read;
  logic        mack_ok;
  logic        cap;

  logic byte_done;
  assign byte_done = scl_fall && (cnt == 4'd8);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '1;
      ptr       <= '0;
      is_read   <= 1'b0;
      mack_ok   <= 1'b0;
      cap       <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
      cap       <= reg_rd_en;
      if (cap) tx <= reg_rdata;

      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end
            if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sr[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  is_read <= sr[0];
                  state   <= ST_ADDR_ACK;
                  if (sr[0]) begin
                    if (in_map(ptr, MAP_END)) begin
                      reg_rd_en <= 1'b1;
                      reg_addr  <= ptr;
                    end else begin
                      tx <= 8'hFF;
                    end
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr    <= ptr_load(sr, MAP_END);
                sda_oe <= 1'b1;
                state  <= ST_PTR_ACK;
              end else begin
                if (reg_writable(ptr, WR_ADDR_A, WR_ADDR_B) && in_map(ptr, MAP_END)) begin
                  reg_wr_en <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= sr;
                end
                ptr    <= ptr_step(ptr, MAP_END);
                sda_oe <= 1'b1;
                state  <= ST_WDATA_ACK;
              end
            end
          end

          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                sda_oe <= ~tx[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end

          ST_PTR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end

          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end

          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                ptr    <= ptr_step(ptr, MAP_END);
                state  <= ST_MACK;
              end else begin
                tx     <= {tx[6:0], 1'b1};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end

          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
              if (!sda_s) begin
                if (in_map(ptr, MAP_END)) begin
                  reg_rd_en <= 1'b1;
                  reg_addr  <= ptr;
                end else begin
                  tx <= 8'hFF;
                end
              end
            end
            if (scl_fall) begin
              cnt <= '0;
              if (mack_ok) begin
                sda_oe <= ~tx[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end

          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h32,
  parameter int         MAP_BYTES   = 112,
  parameter logic [7:0] WR_ADDR_A   = 8'h04,
  parameter logic [7:0] WR_ADDR_B   = 8'h56,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rdata,
  output logic       reg_wr_en,
  output logic [7:0] reg_wdata
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_raw;
  logic [NPINS-1:0] pins_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic busy;

  assign pins_raw = {scl_i, sda_i};

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_sync
    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw[gi]),
      .q    (pins_s[gi])
    );
  end

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_tgt_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .MAP_BYTES(MAP_BYTES),
    .WR_ADDR_A(WR_ADDR_A),
    .WR_ADDR_B(WR_ADDR_B)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .busy     (busy)
  );
endmodule

// File: rtl/i2c_regmap_target_chk.sv
module i2c_regmap_target_chk #(
  parameter int         MAP_BYTES = 112,
  parameter logic [7:0] WR_ADDR_A = 8'h04,
  parameter logic [7:0] WR_ADDR_B = 8'h56
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       busy,
  input logic       sda_oe,
  input logic [7:0] reg_addr,
  input logic       reg_rd_en,
  input logic       reg_wr_en
);
  a_r12_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r12_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  a_r8_rd_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> (reg_addr < 8'(MAP_BYTES)));

  a_r4_wr_writable: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_addr == WR_ADDR_A || reg_addr == WR_ADDR_B));

  a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  a_r13_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd_en, reg_wr_en}));
endmodule

bind i2c_regmap_target i2c_regmap_target_chk #(
  .MAP_BYTES(MAP_BYTES),
  .WR_ADDR_A(WR_ADDR_A),
  .WR_ADDR_B(WR_ADDR_B)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .busy     (busy),
  .sda_oe   (sda_oe),
  .reg_addr (reg_addr),
  .reg_rd_en(reg_rd_en),
  .reg_wr_en(reg_wr_en)
);

// File: tb/i2c_regmap_target_test.sv
module i2c_regmap_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [7:0] reg_addr;
  logic reg_rd_en, reg_wr_en;
  logic [7:0] reg_rdata = 8'h00;
  logic [7:0] reg_wdata;

  int n_chk = 0, n_fail = 0;
  int wr_count = 0, bad_rd = 0, oe_viol = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
  logic [7:0] mem [0:111];
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regmap_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata)
  );

  initial for (int i = 0; i < 112; i++) mem[i] = 8'(i * 7 + 3);

  // Register file model: one cycle read latency.
  always @(posedge clk) begin
    if (reg_rd_en) begin
      if (reg_addr < 8'd112) reg_rdata <= mem[reg_addr[6:0]];
      else begin reg_rdata <= 8'hEE; bad_rd <= bad_rd + 1; end
    end
    if (reg_wr_en) begin
      wr_count <= wr_count + 1;
      last_wa  <= reg_addr;
      last_wd  <= reg_wdata;
      if (reg_addr < 8'd112) mem[reg_addr[6:0]] <= reg_wdata;
    end
    prev_oe <= sda_oe;
    if (rst_n && (sda_oe != prev_oe) && scl) oe_viol <= oe_viol + 1;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(10); scl = 1'b1; wclk(10);
    sda_m = 1'b0; wclk(10); scl = 1'b0; wclk(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(10); scl = 1'b1; wclk(10);
    sda_m = 1'b1; wclk(10);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(10); scl = 1'b1; wclk(20); scl = 1'b0; wclk(10);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(10); scl = 1'b1; wclk(10); b = sda_line;
    wclk(10); scl = 1'b0; wclk(10);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(ack_it ? 1'b0 : 1'b1);
  endtask

  localparam logic [7:0] AW = 8'h64;  // 0x32 with write bit
  localparam logic [7:0] AR = 8'h65;  // 0x32 with read bit

  task automatic t_reset();
    logic [7:0] v; bit a;
    check(sda_oe == 1'b0 && reg_rd_en == 1'b0 && reg_wr_en == 1'b0, "R1 idle outputs",
          {sda_oe, reg_rd_en, reg_wr_en}, 0);
    bus_start(); send_byte(AR, a); recv_byte(1'b0, v); bus_stop();
    check(a, "R2 read address ack", a, 1);
    check(v == mem[0], "R1 pointer at zero after reset", v, mem[0]);
  endtask

  task automatic t_wrong_addr();
    bit a1, a2; int wc;
    wc = wr_count;
    bus_start(); send_byte(8'h66, a1); send_byte(8'h04, a2); send_byte(8'h11, a2); bus_stop();
    check(!a1, "R2 foreign address not acked", a1, 0);
    check(!a2, "R2 bytes after foreign address ignored", a2, 0);
    check(wr_count == wc, "R2 no write for foreign address", wr_count, wc);
  endtask

  task automatic t_write_rw();
    bit a0, a1, a2, a3; int wc;
    wc = wr_count;
    bus_start(); send_byte(AW, a0); send_byte(8'h04, a1); send_byte(8'h5A, a2);
    send_byte(8'h77, a3); bus_stop();
    check(a0 && a1, "R3 write address and pointer acked", {a0, a1}, 3);
    check(a2, "R4 value byte acked", a2, 1);
    check(wr_count == wc + 1 && last_wa == 8'h04 && last_wd == 8'h5A, "R4 write strobe",
          {last_wa, last_wd}, 16'h045A);
    check(!a3, "R6 second value byte not acked", a3, 0);
    check(mem[5] == 8'(5 * 7 + 3), "R6 no write to next address", mem[5], 8'(5 * 7 + 3));
  endtask

  task automatic t_write_ro();
    bit a0, a1, a2; int wc; logic [7:0] v;
    wc = wr_count;
    bus_start(); send_byte(AW, a0); send_byte(8'h10, a1); send_byte(8'h99, a2); bus_stop();
    check(a2, "R5 read-only value acked", a2, 1);
    check(wr_count == wc, "R5 no strobe for read-only", wr_count, wc);
    bus_start(); send_byte(AW, a0); send_byte(8'h10, a1);
    bus_start(); send_byte(AR, a0); recv_byte(1'b0, v); bus_stop();
    check(v == 8'(16 * 7 + 3), "R5 read-only register unchanged", v, 8'(16 * 7 + 3));
  endtask

  task automatic t_burst();
    bit a0, a1, a2; logic [7:0] v0, v1, v2;
    bus_start(); send_byte(AW, a0); send_byte(8'h03, a1);
    bus_start(); send_byte(AR, a2);
    check(a2, "R11 repeated start restarts address phase", a2, 1);
    recv_byte(1'b1, v0); recv_byte(1'b1, v1); recv_byte(1'b0, v2);
    // R13: each byte depends on reg_rdata captured one cycle after reg_rd_en
    check(v0 == mem[3] && v1 == 8'h5A && v2 == mem[5], "R7 R13 consecutive burst",
          {v0, v1, v2}, {mem[3], 8'h5A, mem[5]});
    wclk(5);
    check(sda_oe == 1'b0 && sda_line == 1'b1, "R9 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_continue();
    bit a; logic [7:0] v0, v1;
    bus_start(); send_byte(AR, a); recv_byte(1'b1, v0); recv_byte(1'b0, v1); bus_stop();
    check(v0 == mem[6] && v1 == mem[7], "R10 pointer kept across stop", {v0, v1},
          {mem[6], mem[7]});
  endtask

  task automatic t_end();
    bit a0, a1; logic [7:0] v0, v1, v2, v3, v4;
    bus_start(); send_byte(AW, a0); send_byte(8'h6E, a1);
    bus_start(); send_byte(AR, a0);
    recv_byte(1'b1, v0); recv_byte(1'b1, v1); recv_byte(1'b1, v2); recv_byte(1'b0, v3);
    bus_stop();
    check(v0 == mem[110] && v1 == mem[111], "R8 last registers", {v0, v1},
          {mem[110], mem[111]});
    check(v2 == 8'hFF && v3 == 8'hFF, "R8 past end reads 0xFF", {v2, v3}, 16'hFFFF);
    check(bad_rd == 0, "R8 no read strobe beyond map", bad_rd, 0);
    bus_start(); send_byte(AR, a0); recv_byte(1'b0, v4); bus_stop();
    check(v4 == 8'hFF, "R10 pointer saturated at map end", v4, 8'hFF);
  endtask

  initial begin
    wclk(5); rst_n = 1'b1; wclk(20);
    t_reset();
    t_wrong_addr();
    t_write_rw();
    t_write_ro();
    t_burst();
    t_continue();
    t_end();
    check(oe_viol == 0, "R12 sda_oe steady while SCL high", oe_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule